// File: doc/BRIEF.md
# Alias-Addressed Co-processor Register Bank

This block is the control and status register file of a multi-channel co-processor. A 32-bit read/write bus reaches it. Each register sits on a 16-byte boundary. Address bits 3:2 pick how a write lands:

- `00` replaces the writable bits.
- `01` ORs the data in.
- `10` clears the bits written as one.
- `11` inverts the bits written as one.

Software can therefore change single bits without a read-modify-write, and a read at any of the four addresses returns the same register.

The bank holds a global control register, a global status register, a channel control register, and four 32-bit registers for each channel. The per-channel registers are a command pointer, a semaphore, a status word and an options word.

The channel engines are outside this block and connect through input ports:
- a done pulse per channel raises that channel's interrupt flag;
- a status-update strobe ORs an error word into the channel status register;
- key-ready, current-channel and ready-channel inputs appear as read-only fields of the global status register.

Interrupt flags are masked by enables in the control register and drive one line per channel. Channel 0 can instead be steered onto a separate merged line. The control register also drives the soft-reset and clock-gate outputs. While soft reset is set, every other register is forced to its reset value.

Top module: `scta_regbank`

## Requirements
- R1: After reset the control register reads 0xC000_0000 plus the presence bits. Soft reset is bit 31 and clock gate is bit 30; bit 29 is `CIPHER_PRESENT` and bit 28 is `HASH_PRESENT`. The status register (0x010), the channel control register (0x020) and every channel register read their reset value of zero. Status also shows its live input fields.
- R2: A write changes only the writable bits of the addressed register, and offset bits 3:2 choose the operation. `00` replaces, `01` ORs, `10` clears the ones written, and `11` XORs.
- R3: A read from a base address or from any of its three alias addresses returns the base register's value.
- R4: Read-only bits ignore every write operation. These are the presence bits (29, 28) in control, and in status the key-ready bit 28, current channel in bits 27:24 and ready channels in bits 23:16. Those status fields always show the `key_ready`, `cur_chan` and `ready_chan` inputs.
- R5: The writable bits of the control register are 31, 30, 23, 22, 21 and the per-channel interrupt enables in bits 3:0. The writable bits of channel control are the enables in bits 3:0, the high-priority flags in bits 11:8 and the channel-0 merge bit 16. All other bits of both registers read zero.
- R6: Channel n's pointer, semaphore, status and options registers sit at 0x100, 0x110, 0x120 and 0x130, each plus n×0x40. All four are fully writable 32-bit registers.
- R7: A `ch_done[n]` pulse sets status flag n (status bits 3:0), and the flag stays set until software clears it. If the pulse and a software clear of the same flag fall in the same cycle, the flag stays set.
- R8: `ch_irq[n]` is high exactly when flag n and control enable bit n are both one. The exception is channel 0 when channel-control bit 16 is one: its request then appears on `irq_merged`, and `ch_irq[0]` stays low.
- R9: `soft_rst_o` and `clk_gate_o` follow control bits 31 and 30. While bit 31 is one, every register other than control holds its reset value: writes and engine events have no effect, and the interrupt outputs are low.
- R10: A `ch_stat_upd[n]` strobe ORs `ch_stat_bits[32n+31:32n]` into channel n's status register.
- R11: These addresses are unmapped: any address with bits 1:0 non-zero, and any address outside the three global registers and the groups of existing channels. An unmapped address reads zero, and a write to it changes no register.
- R12: Read data and `rvalid` appear on the cycle after `rd_en`, and `rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address, bits 3:2 select the alias operation |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rvalid | output | 1 | Read data valid |
| ch_done | input | NCH | Per-channel completion pulses |
| ch_stat_upd | input | NCH | Per-channel status update strobes |
| ch_stat_bits | input | 32*NCH | Status words ORed into channel status registers |
| key_ready | input | 1 | Key-ready indication shown in status |
| cur_chan | input | 4 | Current channel shown in status |
| ready_chan | input | 8 | Ready-channel field shown in status |
| ch_irq | output | NCH | Per-channel interrupt lines |
| irq_merged | output | 1 | Merged line carrying channel 0 when steered |
| soft_rst_o | output | 1 | Soft reset control |
| clk_gate_o | output | 1 | Clock gate control |

## Verification
The bench builds the bank with four channels, `CIPHER_PRESENT` at one and `HASH_PRESENT` at zero. With the two presence bits different, a write that leaks into either one shows as a wrong value in bit 29 or bit 28. Four channels bring the full 0x40 group stride and the top group at 0x1C0 within reach. They also let two channels' interrupt flags be set while a third is masked. The bench drives the done-versus-clear collision and the soft-reset hold through the bus and the interrupt pins.

// File: rtl/scta_pkg.sv
package scta_pkg;

    localparam int DW = 32;

    // Alias operation taken from address bits 3:2
    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_SET   = 2'b01,
        OP_CLR   = 2'b10,
        OP_TGL   = 2'b11
    } alias_op_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CHCTRL,
        SEL_CHAN
    } reg_sel_e;

    // Slot order inside a channel group
    localparam logic [1:0] SLOT_PTR  = 2'd0;
    localparam logic [1:0] SLOT_SEMA = 2'd1;
    localparam logic [1:0] SLOT_STAT = 2'd2;
    localparam logic [1:0] SLOT_OPT  = 2'd3;

    typedef struct packed {
        reg_sel_e  sel;
        logic [1:0] chan;
        logic [1:0] slot;
        alias_op_e op;
    } dec_t;

    // Apply one alias operation, touching only bits in mask
    function automatic logic [DW-1:0] apply_op(alias_op_e op, logic [DW-1:0] cur,
                                               logic [DW-1:0] wd, logic [DW-1:0] mask);
        logic [DW-1:0] nxt;
        unique case (op)
            OP_WRITE: nxt = wd;
            OP_SET:   nxt = cur | wd;
            OP_CLR:   nxt = cur & ~wd;
            OP_TGL:   nxt = cur ^ wd;
        endcase
        return (cur & ~mask) | (nxt & mask);
    endfunction

endpackage

// File: rtl/scta_decode.sv
module scta_decode
    import scta_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam int GRP_W = ADDR_W - 4;
    localparam int BLK_W = ADDR_W - 8;

    always_comb begin
        dec.sel  = SEL_NONE;
        dec.chan = addr[7:6];
        dec.slot = addr[5:4];
        dec.op   = alias_op_e'(addr[3:2]);
        if (addr[1:0] == 2'b00) begin
            if (addr[ADDR_W-1:4] == GRP_W'(0)) begin
                dec.sel = SEL_CTRL;
            end else if (addr[ADDR_W-1:4] == GRP_W'(1)) begin
                dec.sel = SEL_STAT;
            end else if (addr[ADDR_W-1:4] == GRP_W'(2)) begin
                dec.sel = SEL_CHCTRL;
            end else if (addr[ADDR_W-1:8] == BLK_W'(1) && int'(addr[7:6]) < NCH) begin
                dec.sel = SEL_CHAN;
            end
        end
    end

endmodule

// File: rtl/scta_reg.sv
module scta_reg
    import scta_pkg::*;
#(
    parameter logic [DW-1:0] RST_VAL = '0,
    parameter logic [DW-1:0] WR_MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          we,
    input  alias_op_e     op,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] hw_set,
    output logic [DW-1:0] q
);

    logic [DW-1:0] d;

    always_comb begin
        d = q;
        if (we) begin
            d = apply_op(op, q, wdata, WR_MASK);
        end
        // hardware events win over a software clear in the same cycle
        d = d | (hw_set & WR_MASK);
        if (hold) begin
            d = RST_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/scta_irq.sv
module scta_irq #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] flags,
    input  logic [NCH-1:0] enables,
    input  logic           merge_ch0,
    output logic [NCH-1:0] ch_irq,
    output logic           irq_merged
);

    logic [NCH-1:0] raw;

    for (genvar n = 0; n < NCH; n++) begin : g_line
        assign raw[n] = flags[n] & enables[n];
        if (n == 0) begin : g_ch0
            assign ch_irq[n] = raw[n] & ~merge_ch0;
        end else begin : g_chn
            assign ch_irq[n] = raw[n];
        end
    end

    assign irq_merged = raw[0] & merge_ch0;

endmodule

// File: rtl/scta_regbank.sv
module scta_regbank
    import scta_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int NCH            = 4,
    parameter bit CIPHER_PRESENT = 1'b1,
    parameter bit HASH_PRESENT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic [NCH-1:0]    ch_done,
    input  logic [NCH-1:0]    ch_stat_upd,
    input  logic [32*NCH-1:0] ch_stat_bits,
    input  logic              key_ready,
    input  logic [3:0]        cur_chan,
    input  logic [7:0]        ready_chan,
    output logic [NCH-1:0]    ch_irq,
    output logic              irq_merged,
    output logic              soft_rst_o,
    output logic              clk_gate_o
);

    localparam logic [DW-1:0] CH_MASK      = DW'((1 << NCH) - 1);
    localparam logic [DW-1:0] SRST_BIT     = 32'h8000_0000;
    localparam logic [DW-1:0] CTRL_RST     = 32'hC000_0000;
    localparam logic [DW-1:0] CTRL_WMASK   = 32'hC0E0_0000 | CH_MASK;
    localparam logic [DW-1:0] CTRL_RO      = {2'b00, CIPHER_PRESENT, HASH_PRESENT, 28'h0};
    localparam logic [DW-1:0] CHCTRL_WMASK = 32'h0001_0000 | (CH_MASK << 8) | CH_MASK;
    localparam int            NREG         = 4 * NCH;

    dec_t          dec;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] chctrl_q;
    logic [DW-1:0] chan_q [NREG];
    logic [DW-1:0] ctrl_try;
    logic          srst_next;
    logic          we_ctrl;
    logic          we_stat;
    logic          we_chctrl;
    logic [DW-1:0] rd_val;

    scta_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) dec_i (
        .addr (addr),
        .dec  (dec)
    );

    assign we_ctrl   = wr_en && (dec.sel == SEL_CTRL);
    assign we_stat   = wr_en && (dec.sel == SEL_STAT);
    assign we_chctrl = wr_en && (dec.sel == SEL_CHCTRL);

    // Soft reset takes effect on the same edge as the write that sets it
    assign ctrl_try  = apply_op(dec.op, ctrl_q, wdata, CTRL_WMASK);
    assign srst_next = we_ctrl ? |(ctrl_try & SRST_BIT) : |(ctrl_q & SRST_BIT);

    scta_reg #(.RST_VAL(CTRL_RST), .WR_MASK(CTRL_WMASK)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (1'b0),
        .we     (we_ctrl),
        .op     (dec.op),
        .wdata  (wdata),
        .hw_set ('0),
        .q      (ctrl_q)
    );

    scta_reg #(.RST_VAL('0), .WR_MASK(CH_MASK)) stat_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (srst_next),
        .we     (we_stat),
        .op     (dec.op),
        .wdata  (wdata),
        .hw_set (DW'(ch_done)),
        .q      (stat_q)
    );

    scta_reg #(.RST_VAL('0), .WR_MASK(CHCTRL_WMASK)) chctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (srst_next),
        .we     (we_chctrl),
        .op     (dec.op),
        .wdata  (wdata),
        .hw_set ('0),
        .q      (chctrl_q)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        for (genvar s = 0; s < 4; s++) begin : g_slot
            logic [DW-1:0] hw;
            logic          we_slot;
            if (s == int'(SLOT_STAT)) begin : g_stat
                assign hw = ch_stat_upd[n] ? ch_stat_bits[n*32 +: 32] : '0;
            end else begin : g_plain
                assign hw = '0;
            end
            assign we_slot = wr_en && (dec.sel == SEL_CHAN) &&
                             (dec.chan == 2'(n)) && (dec.slot == 2'(s));
            scta_reg #(.RST_VAL('0), .WR_MASK('1)) r_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .hold   (srst_next),
                .we     (we_slot),
                .op     (dec.op),
                .wdata  (wdata),
                .hw_set (hw),
                .q      (chan_q[n*4+s])
            );
        end
    end

    scta_irq #(.NCH(NCH)) irq_i (
        .flags      (stat_q[NCH-1:0]),
        .enables    (ctrl_q[NCH-1:0]),
        .merge_ch0  (chctrl_q[16]),
        .ch_irq     (ch_irq),
        .irq_merged (irq_merged)
    );

    always_comb begin
        rd_val = '0;
        unique case (dec.sel)
            SEL_CTRL:   rd_val = ctrl_q | CTRL_RO;
            SEL_STAT:   rd_val = {3'b000, key_ready, cur_chan, ready_chan, 16'h0000} | stat_q;
            SEL_CHCTRL: rd_val = chctrl_q;
            SEL_CHAN:   rd_val = chan_q[int'(dec.chan)*4 + int'(dec.slot)];
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= rd_val;
            end
        end
    end

    assign soft_rst_o = ctrl_q[31];
    assign clk_gate_o = ctrl_q[30];

endmodule

// File: rtl/scta_chk.sv
module scta_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_en,
    input logic           rvalid,
    input logic [NCH-1:0] ch_done,
    input logic           soft_rst_o,
    input logic [NCH-1:0] ch_irq,
    input logic           irq_merged,
    input logic [NCH-1:0] flags,
    input logic           merge
);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R12

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid); // R12

    AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (flags == '0 && ch_irq == '0 && !irq_merged)); // R9

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done != '0) |=> (soft_rst_o || ((flags & $past(ch_done)) == $past(ch_done)))); // R7

    AST_MERGE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_irq[0] |-> !merge) and (irq_merged |-> merge)); // R8

endmodule

bind scta_regbank scta_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rvalid     (rvalid),
    .ch_done    (ch_done),
    .soft_rst_o (soft_rst_o),
    .ch_irq     (ch_irq),
    .irq_merged (irq_merged),
    .flags      (stat_q[NCH-1:0]),
    .merge      (chctrl_q[16])
);

// File: tb/scta_regbank_tb_top.sv
module scta_regbank_tb_top;

    localparam int ADDR_W = 12;
    localparam int NCH    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid;
    logic [NCH-1:0]    ch_done = '0;
    logic [NCH-1:0]    ch_stat_upd = '0;
    logic [32*NCH-1:0] ch_stat_bits = '0;
    logic              key_ready = 1'b0;
    logic [3:0]        cur_chan = '0;
    logic [7:0]        ready_chan = '0;
    logic [NCH-1:0]    ch_irq;
    logic              irq_merged;
    logic              soft_rst_o;
    logic              clk_gate_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    scta_regbank #(
        .ADDR_W(ADDR_W), .NCH(NCH), .CIPHER_PRESENT(1'b1), .HASH_PRESENT(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .ch_done(ch_done),
        .ch_stat_upd(ch_stat_upd), .ch_stat_bits(ch_stat_bits),
        .key_ready(key_ready), .cur_chan(cur_chan), .ready_chan(ready_chan),
        .ch_irq(ch_irq), .irq_merged(irq_merged), .soft_rst_o(soft_rst_o),
        .clk_gate_o(clk_gate_o)
    );

    // Monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R12: unexpected rvalid, rdata=%08h expected no data", rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata=%08h expected %08h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: pushes the expected value, then issues the read
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_done(input logic [NCH-1:0] m);
        @(negedge clk);
        ch_done = m;
        @(negedge clk);
        ch_done = '0;
    endtask

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", t, act, e);
        end
    endtask

    function automatic logic [ADDR_W-1:0] ch_addr(input int n, input int s);
        return ADDR_W'(32'h100 + n * 32'h40 + s * 32'h10);
    endfunction

    function automatic logic [31:0] ch_val(input int n, input int s);
        return 32'hC0DE_0000 | 32'(n << 8) | 32'(s << 4);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] st2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(12'h000, 32'hE000_0000, "R1 ctrl reset");
        rd(12'h010, 32'h0, "R1 stat reset");
        rd(12'h020, 32'h0, "R1 chctrl reset");
        rd(ch_addr(3, 3), 32'h0, "R1 chan reset");
        chk("R9 soft_rst_o at reset", 32'(soft_rst_o), 32'd1);
        chk("R9 clk_gate_o at reset", 32'(clk_gate_o), 32'd1);

        // R9 writes and events ignored while soft reset is set
        wr(12'h020, 32'h0000_000F);
        wr(ch_addr(1, 0), 32'h1234);
        pulse_done(4'hF);
        chk("R9 irq low in soft reset", 32'({irq_merged, ch_irq}), 32'h0);
        rd(12'h020, 32'h0, "R9 chctrl held");
        rd(ch_addr(1, 0), 32'h0, "R9 chan ptr held");
        rd(12'h010, 32'h0, "R9 stat flags held");

        // R2 clear alias releases soft reset and clock gate
        wr(12'h008, 32'hC000_0000);
        chk("R2 soft_rst_o cleared", 32'(soft_rst_o), 32'd0);
        chk("R2 clk_gate_o cleared", 32'(clk_gate_o), 32'd0);
        rd(12'h000, 32'h2000_0000, "R2 ctrl after clear alias");

        // R5 writable mask, R4 presence bits, R2 set/toggle/clear
        wr(12'h000, 32'h3FFF_FFFF);
        rd(12'h000, 32'h20E0_000F, "R5 ctrl plain write mask");
        wr(12'h00C, 32'h3000_0001);
        rd(12'h000, 32'h20E0_000E, "R2 R4 ctrl toggle alias");
        wr(12'h004, 32'h0000_0001);
        rd(12'h000, 32'h20E0_000F, "R2 ctrl set alias");
        wr(12'h008, 32'h00E0_0000);
        // R3 reads through every alias
        rd(12'h000, 32'h2000_000F, "R3 ctrl base");
        rd(12'h004, 32'h2000_000F, "R3 ctrl set alias read");
        rd(12'h008, 32'h2000_000F, "R3 ctrl clear alias read");
        rd(12'h00C, 32'h2000_000F, "R3 ctrl toggle alias read");

        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, 32'h0001_0F0F, "R5 chctrl mask");
        rd(12'h028, 32'h0001_0F0F, "R3 chctrl alias read");
        wr(12'h020, 32'h0);
        rd(12'h020, 32'h0, "R2 chctrl plain write");

        // R6 channel group layout
        for (int n = 0; n < NCH; n++)
            for (int s = 0; s < 4; s++)
                wr(ch_addr(n, s), ch_val(n, s));
        for (int n = 0; n < NCH; n++)
            for (int s = 0; s < 4; s++)
                rd(ch_addr(n, s), ch_val(n, s), "R6 chan reg readback");
        wr(ADDR_W'(ch_addr(3, 3) + 12'h4), 32'h3);
        rd(ch_addr(3, 3), ch_val(3, 3) | 32'h3, "R2 R6 chan set alias");

        // R10 engine status update
        @(negedge clk);
        ch_stat_upd = 4'b0100;
        ch_stat_bits[2*32 +: 32] = 32'h0001_0001;
        @(negedge clk);
        ch_stat_upd = '0;
        st2 = ch_val(2, 2) | 32'h0001_0001;
        rd(ch_addr(2, 2), st2, "R10 chan status OR update");
        rd(ch_addr(2, 1), ch_val(2, 1), "R10 neighbour untouched");

        // R11 unmapped addresses
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h002, 32'hFFFF_FFFF);
        rd(12'h040, 32'h0, "R11 unmapped 0x040");
        rd(12'h030, 32'h0, "R11 unmapped 0x030");
        rd(12'h002, 32'h0, "R11 misaligned");
        rd(12'h200, 32'h0, "R11 beyond channels");
        rd(12'h000, 32'h2000_000F, "R11 ctrl untouched");

        // R7 R8 flags and interrupt routing
        key_ready = 1'b1; cur_chan = 4'h2; ready_chan = 8'h0A;
        pulse_done(4'b0101);
        chk("R7 R8 ch_irq after done", 32'(ch_irq), 32'h5);
        chk("R8 merged idle", 32'(irq_merged), 32'h0);
        rd(12'h010, 32'h120A_0005, "R7 R4 stat flags and fields");
        wr(12'h018, 32'h1);
        chk("R7 clear alias drops flag", 32'(ch_irq), 32'h4);
        wr(12'h024, 32'h0001_0000);
        pulse_done(4'b0001);
        chk("R8 merged ch0 line low", 32'(ch_irq), 32'h4);
        chk("R8 merged line high", 32'(irq_merged), 32'h1);
        wr(12'h008, 32'h4);
        chk("R8 masked channel 2", 32'(ch_irq), 32'h0);
        chk("R8 merged stays", 32'(irq_merged), 32'h1);

        // R7 done wins over simultaneous clear
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h018; wdata = 32'h2; ch_done = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; ch_done = '0;
        rd(12'h010, 32'h120A_0007, "R7 set beats clear");
        chk("R8 ch_irq with en 1011", 32'(ch_irq), 32'h2);

        // R4 read-only status fields and presence bits
        wr(12'h01C, 32'hFFFF_0000);
        rd(12'h010, 32'h120A_0007, "R4 stat fields ignore toggle");
        wr(12'h00C, 32'h3000_0000);
        rd(12'h000, 32'h2000_000B, "R4 presence bits ignore toggle");

        // R9 setting soft reset clears the rest
        wr(12'h004, 32'h8000_0000);
        chk("R9 soft_rst_o set", 32'(soft_rst_o), 32'd1);
        chk("R9 clk_gate_o stays", 32'(clk_gate_o), 32'd0);
        chk("R9 irq dropped", 32'({irq_merged, ch_irq}), 32'h0);
        rd(12'h000, 32'hA000_000B, "R9 ctrl keeps value");
        rd(12'h010, 32'h120A_0000, "R9 flags cleared");
        rd(ch_addr(2, 2), 32'h0, "R9 chan status cleared");
        rd(12'h020, 32'h0, "R9 chctrl cleared");

        repeat (3) @(negedge clk);
        chk("R12 all reads returned", 32'(exp_q.size()), 32'd0);
        chk("R12 rvalid idle", 32'(rvalid), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule